// File: doc/BRIEF.md
# Byte-Serial SPI Master with Directional FIFO

This block is the serial engine of a chip-level SPI master. Software programs it through eight byte-wide registers: it picks SCK polarity, bit order and the FIFO direction, loads a 16-bit byte count, and then either fills the FIFO with bytes to send or drains the bytes the engine has collected. The engine shifts one byte at a time on SCK/MOSI and samples MISO. The SCK rate is the system clock divided by a programmable 8-bit value.

The eight-entry FIFO sits between the register port and the shifter. Internally both of its sides are valid/ready streams, and the rules for back-pressure are simple. A register write into a full FIFO is refused and raises the FIFO error flag. A register read from an empty receive FIFO returns zero and raises the same flag. The shifter never starts a byte unless the FIFO can supply it (transmit direction) or take it (receive direction), so SCK simply pauses instead of sending stale data or losing received data.

Four sticky flags report progress: byte done, FIFO half full, FIFO error and count reached. Each flag has an enable, and one interrupt line ORs the enabled flags. A control bit resets the FIFO, the count, the flags and the shifter in one write.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, CTRL (addr 0) reads 0x00, which means SCK idles low, MSB first and transmit direction. DIV (addr 3) reads 0x02, FLAG (addr 2) reads 0x80, LEVEL (addr 5) reads 0, SCK is low and irq is low.
- R2: A byte is 8 SCK pulses. Consecutive SCK rising edges within a byte are exactly DIV system clocks apart, with the low phase DIV-floor(DIV/2) and the high phase floor(DIV/2) clocks. Writing a DIV value below 2 stores 2.
- R3: CTRL bit1 sets the SCK idle level: 0 gives idle low (mode 0), 1 gives idle high (mode 3). Data always changes on the falling edge and is sampled on the rising edge.
- R4: CTRL bit3 selects LSB first (1) or MSB first (0). This applies both to MOSI and to how MISO bits, sampled at each rising SCK edge, build the received byte.
- R5: With CTRL bit2 = 0 (transmit), a write to DATA (addr 4) pushes one byte into the 8-entry FIFO. A write while LEVEL is 8 is dropped and sets FLAG bit2.
- R6: With CTRL bit2 = 1 (receive), each received byte is pushed into the FIFO, MOSI sends 0xFF, and a DATA read pops the oldest byte. A DATA read while the FIFO is empty returns 0x00 and sets FLAG bit2.
- R7: Writing COUNT_LO (addr 6) and then COUNT_HI (addr 7) loads a 16-bit count of bytes still to move, which reads back on those addresses. Each completed byte decrements it, and the last byte sets FLAG bit3.
- R8: While bytes remain, SCK stays at its idle level if the transmit FIFO is empty or the receive FIFO is full, and it resumes once that condition clears.
- R9: Every completed byte sets FLAG bit0. FLAG bit1 is set when the FIFO level rises from 3 to 4.
- R10: Writing 1 to a FLAG bit in [3:0] clears it, and writing 0 leaves it. irq is the OR of FLAG[3:0] ANDed with IEN (addr 1) bits [3:0].
- R11: With CTRL bit4 set, any DATA read or write clears FLAG bit0.
- R12: Writing CTRL with bit0 = 1 empties the FIFO, zeroes the count, clears FLAG[3:0] and stops the shifter. Bit0 always reads 0.
- R13: FLAG bit7 reads 1 only when the count is zero and the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops DATA in receive direction) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the next clock edge. FIFO level and flag changes can therefore be read back in the following cycle. A byte needs one start cycle, 8×DIV clocks of SCK and one completion cycle, and the count, count-reached and free bits update at the edge after completion. The bench reads registers half a cycle after an edge, so it always sees settled values. It waits on the free bit with a bounded poll instead of guessing the total latency. It times SCK rising edges in absolute time against DIV×20 ns. A scoreboard compares every byte seen on MOSI, in order, with the bytes queued by the driver.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W = 8;
  localparam int CNT_W = 16;
  localparam int NFLAGS = 4;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_IEN   = 3'd1,
    A_FLAG  = 3'd2,
    A_DIV   = 3'd3,
    A_DATA  = 3'd4,
    A_LEVEL = 3'd5,
    A_CNTL  = 3'd6,
    A_CNTH  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_e;

  typedef struct packed {
    logic auto_be;
    logic lsb_first;
    logic rx_dir;
    logic idle_high;
  } ctrl_t;

  localparam int F_BYTE = 0;
  localparam int F_HALF = 1;
  localparam int F_ERR  = 2;
  localparam int F_CEND = 3;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [LW-1:0] level,
  output logic          half_cross
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_M1 = LW'(DEPTH / 2 - 1);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic push, pop;

  assign in_ready  = (level != FULL);
  assign out_valid = (level != '0);
  assign push = in_valid && in_ready;
  assign pop  = out_valid && out_ready;
  assign out_data = mem[rp];
  assign half_cross = push && !pop && (level == HALF_M1);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      if (push && !pop) level <= level + LW'(1);
      else if (pop && !push) level <= level - LW'(1);
    end
  end

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready && !flush) |=> $stable(level));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W = 8,
  parameter int DW = 8,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          idle_high,
  input  logic          lsb_first,
  input  logic [DW-1:0] div,
  input  logic          start,
  input  logic [W-1:0]  tx_byte,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rx_byte,
  output logic          sck,
  output logic          mosi
);
  import spim_pkg::*;

  sh_state_e st;
  logic [DW-1:0] cnt, lo_len, hi_len;
  logic [BW-1:0] bitn;
  logic [W-1:0] txsh, rxsh;

  assign hi_len = div >> 1;
  assign lo_len = div - hi_len;
  assign busy = (st != SH_IDLE);
  assign rx_byte = rxsh;
  assign mosi = lsb_first ? txsh[0] : txsh[W-1];

  always_comb begin
    case (st)
      SH_LOW:  sck = 1'b0;
      SH_HIGH: sck = 1'b1;
      default: sck = idle_high;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE;
      cnt <= '0;
      bitn <= '0;
      txsh <= '0;
      rxsh <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= SH_IDLE;
      end else begin
        case (st)
          SH_IDLE: if (start) begin
            txsh <= tx_byte;
            bitn <= '0;
            cnt <= lo_len - DW'(1);
            st <= SH_LOW;
          end
          SH_LOW: if (cnt == '0) begin
            rxsh <= lsb_first ? {miso, rxsh[W-1:1]} : {rxsh[W-2:0], miso};
            cnt <= hi_len - DW'(1);
            st <= SH_HIGH;
          end else begin
            cnt <= cnt - DW'(1);
          end
          SH_HIGH: if (cnt == '0) begin
            if (bitn == BW'(W - 1)) begin
              st <= SH_IDLE;
              done <= 1'b1;
            end else begin
              txsh <= lsb_first ? (txsh >> 1) : (txsh << 1);
              bitn <= bitn + BW'(1);
              cnt <= lo_len - DW'(1);
              st <= SH_LOW;
            end
          end else begin
            cnt <= cnt - DW'(1);
          end
          default: st <= SH_IDLE;
        endcase
      end
    end
  end

  // R2: a byte may only be launched from the idle state
  a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R4: MOSI holds steady through the high phase, where the receiver samples
  a_r4_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SH_HIGH && $past(st) == SH_HIGH) |-> $stable(mosi));
endmodule

// File: rtl/spim_flags.sv
module spim_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [N-1:0] set,
  input  logic         w1c_we,
  input  logic [N-1:0] w1c_mask,
  input  logic [N-1:0] hw_clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr;

  assign clr = (w1c_we ? w1c_mask : '0) | hw_clr;
  assign irq = |(flags & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else if (clear_all) flags <= '0;
    else flags <= (flags & ~clr) | set;
  end

  a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (flags == '0));
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set) && !clear_all) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       irq
);
  import spim_pkg::*;

  localparam logic [DW-1:0] DIV_MIN = DW'(2);

  ctrl_t ctrl_q;
  logic [NFLAGS-1:0] ien_q, flags, set_v, hw_clr;
  logic [DW-1:0] div_q;
  logic [7:0] cnt_stage;
  logic [CNT_W-1:0] remaining;

  logic wr_ctrl, clear_all, wr_cnth, data_acc;
  logic cpu_push, cpu_pop;
  logic f_in_valid, f_in_ready, f_out_valid, f_out_ready, f_half;
  logic [7:0] f_in_data, f_out_data;
  logic [LW-1:0] f_level;
  logic sh_busy, sh_done, sh_start;
  logic [7:0] sh_rx, sh_tx;
  logic free;

  assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
  assign clear_all = wr_ctrl && reg_wdata[0];
  assign wr_cnth   = reg_we && (reg_addr == A_CNTH);
  assign data_acc  = (reg_we || reg_re) && (reg_addr == A_DATA);
  assign cpu_push  = reg_we && (reg_addr == A_DATA) && !ctrl_q.rx_dir;
  assign cpu_pop   = reg_re && (reg_addr == A_DATA) && ctrl_q.rx_dir;

  // FIFO streams: direction bit swaps which side feeds and which drains
  assign f_in_valid  = ctrl_q.rx_dir ? sh_done : cpu_push;
  assign f_in_data   = ctrl_q.rx_dir ? sh_rx : reg_wdata;
  assign f_out_ready = ctrl_q.rx_dir ? cpu_pop : sh_start;

  spim_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clear_all),
    .in_valid(f_in_valid), .in_ready(f_in_ready), .in_data(f_in_data),
    .out_valid(f_out_valid), .out_ready(f_out_ready), .out_data(f_out_data),
    .level(f_level), .half_cross(f_half)
  );

  assign sh_start = !sh_busy && !sh_done && !clear_all && (remaining != '0) &&
                    (ctrl_q.rx_dir ? f_in_ready : f_out_valid);
  assign sh_tx = ctrl_q.rx_dir ? 8'hFF : f_out_data;

  spim_shifter #(.W(8), .DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(clear_all),
    .idle_high(ctrl_q.idle_high), .lsb_first(ctrl_q.lsb_first), .div(div_q),
    .start(sh_start), .tx_byte(sh_tx), .miso(miso),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
    .sck(sck), .mosi(mosi)
  );

  always_comb begin
    set_v = '0;
    set_v[F_BYTE] = sh_done;
    set_v[F_HALF] = f_half;
    set_v[F_ERR]  = (cpu_push && !f_in_ready) ||
                    (reg_re && (reg_addr == A_DATA) && ctrl_q.rx_dir && !f_out_valid);
    set_v[F_CEND] = sh_done && (remaining == CNT_W'(1));
    hw_clr = '0;
    hw_clr[F_BYTE] = ctrl_q.auto_be && data_acc;
  end

  spim_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .set(set_v),
    .w1c_we(reg_we && (reg_addr == A_FLAG)), .w1c_mask(reg_wdata[NFLAGS-1:0]),
    .hw_clr(hw_clr), .ien(ien_q), .flags(flags), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q <= '0;
      div_q <= DIV_MIN;
      cnt_stage <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: ctrl_q <= '{auto_be: reg_wdata[4], lsb_first: reg_wdata[3],
                            rx_dir: reg_wdata[2], idle_high: reg_wdata[1]};
        A_IEN:  ien_q <= reg_wdata[NFLAGS-1:0];
        A_DIV:  div_q <= (DW'(reg_wdata) < DIV_MIN) ? DIV_MIN : DW'(reg_wdata);
        A_CNTL: cnt_stage <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remaining <= '0;
    else if (clear_all) remaining <= '0;
    else if (wr_cnth) remaining <= {reg_wdata, cnt_stage};
    else if (sh_done && remaining != '0) remaining <= remaining - CNT_W'(1);
  end

  assign free = !sh_busy && (remaining == '0);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {3'b000, ctrl_q.auto_be, ctrl_q.lsb_first,
                            ctrl_q.rx_dir, ctrl_q.idle_high, 1'b0};
      A_IEN:   reg_rdata = 8'(ien_q);
      A_FLAG:  reg_rdata = {free, 3'b000, flags};
      A_DIV:   reg_rdata = 8'(div_q);
      A_DATA:  reg_rdata = (ctrl_q.rx_dir && f_out_valid) ? f_out_data : 8'h00;
      A_LEVEL: reg_rdata = 8'(f_level);
      A_CNTL:  reg_rdata = remaining[7:0];
      default: reg_rdata = remaining[15:8];
    endcase
  end

  // R7: each completed byte takes exactly one off the count
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && remaining != '0 && !clear_all && !wr_cnth) |=>
      (remaining == $past(remaining) - CNT_W'(1)));
  // R8: with nothing left to move, the shifter never leaves idle
  a_r8_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining == '0 && !sh_busy && !wr_cnth) |=> !sh_busy);
endmodule

// File: tb/sim_spi_fifo_master.sv
`timescale 1ns/1ps
module sim_spi_fifo_master;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sck, mosi, miso = 0, irq;

  always #10 clk = ~clk;

  spi_fifo_master u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq));

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] slv_q[$];
  logic lsb_b = 0;
  int div_b = 2;
  logic mute = 0;
  int rise_n = 0, mbit = 0, sbit = 0;
  logic [7:0] mbyte = 0;
  time last_rise = 0;
  logic per_ok = 1;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic slv_bit();
    logic [7:0] b;
    b = (slv_q.size() != 0) ? slv_q[0] : 8'h00;
    return lsb_b ? b[sbit] : b[7 - sbit];
  endfunction

  // Monitor: scoreboard on MOSI, slave model on MISO, SCK period timing
  always @(posedge sck) begin
    rise_n++;
    if (!mute) begin
      mbyte = lsb_b ? {mosi, mbyte[7:1]} : {mbyte[6:0], mosi};
      if (mbit > 0 && ($time - last_rise) != div_b * 20) per_ok = 0;
      last_rise = $time;
      mbit++;
      sbit++;
      if (sbit == 8) begin
        sbit = 0;
        if (slv_q.size() != 0) void'(slv_q.pop_front());
      end
      miso = slv_bit();
      if (mbit == 8) begin
        mbit = 0;
        if (exp_q.size() == 0) chk(0, "R4", "unexpected MOSI byte", mbyte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(mbyte == e, "R4", "MOSI byte", mbyte, e);
        end
        chk(per_ok, "R2", "SCK period in DIV clocks", 0, div_b);
        per_ok = 1;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1; #2 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    wr(3'd4, b);
  endtask

  task automatic set_count(input int n);
    wr(3'd6, 8'(n));
    wr(3'd7, 8'(n >> 8));
  endtask

  task automatic wait_free(input string req);
    logic [7:0] f;
    bit got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      rd(3'd2, f);
      if (f[7]) got = 1;
    end
    chk(got, req, "free bit reached", got, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int r0;
    logic [7:0] rxv[10];
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R13 free
    rd(3'd0, v); chk(v == 8'h00, "R1", "CTRL reset", v, 8'h00);
    rd(3'd3, v); chk(v == 8'h02, "R1", "DIV reset", v, 8'h02);
    rd(3'd2, v); chk(v == 8'h80, "R13", "FLAG reset free", v, 8'h80);
    rd(3'd5, v); chk(v == 8'h00, "R1", "LEVEL reset", v, 0);
    chk(sck == 0 && irq == 0, "R1", "sck/irq reset", {sck, irq}, 0);
    // R2 divisor clamp
    wr(3'd3, 8'h01); rd(3'd3, v); chk(v == 8'h02, "R2", "DIV clamp", v, 2);
    wr(3'd3, 8'h04); div_b = 4;
    // Transmit, mode 0, MSB first: R5, R7, R9, R10
    wr(3'd1, 8'h01);
    send(8'hA5); send(8'h3C); send(8'h81);
    rd(3'd5, v); chk(v == 8'd3, "R5", "LEVEL after pushes", v, 3);
    set_count(3);
    wait_free("R7");
    rd(3'd2, v); chk(v == 8'h89, "R9", "byte-end and count-end flags", v, 8'h89);
    chk(irq == 1, "R10", "irq with byte-end enabled", irq, 1);
    rd(3'd6, v); chk(v == 8'h00, "R7", "count drained", v, 0);
    rd(3'd5, v); chk(v == 8'h00, "R5", "FIFO drained", v, 0);
    wr(3'd2, 8'h01); rd(3'd2, v); chk(v == 8'h88, "R10", "W1C byte-end", v, 8'h88);
    chk(irq == 0, "R10", "irq after clear", irq, 0);
    wr(3'd2, 8'h08); rd(3'd2, v); chk(v == 8'h80, "R10", "W1C count-end", v, 8'h80);
    // Mode 3, LSB first, odd divisor: R3, R4, R2
    mute = 1;
    wr(3'd3, 8'h05); div_b = 5;
    wr(3'd0, 8'h0A); lsb_b = 1;
    repeat (2) @(negedge clk);
    mute = 0;
    chk(sck == 1, "R3", "idle-high SCK", sck, 1);
    send(8'h1E); send(8'hC4);
    set_count(2);
    wait_free("R4");
    chk(sck == 1, "R3", "SCK back to idle high", sck, 1);
    // Back to mode 0 MSB first; R8 transmit stall
    wr(3'd0, 8'h00); lsb_b = 0;
    wr(3'd3, 8'h02); div_b = 2;
    wr(3'd2, 8'h0F);
    set_count(2);
    r0 = rise_n;
    repeat (50) @(negedge clk);
    chk(rise_n == r0, "R8", "no SCK with empty TX FIFO", rise_n - r0, 0);
    rd(3'd2, v); chk(v[7] == 0, "R13", "not free while count pending", v[7], 0);
    rd(3'd6, v); chk(v == 8'd2, "R8", "count held during stall", v, 2);
    send(8'h5A); send(8'h69);
    wait_free("R8");
    // R9 half-full, R5 overflow, R10 irq, R12 all-clear
    wr(3'd2, 8'h0F);
    wr(3'd1, 8'h04);
    for (int i = 0; i < 4; i++) wr(3'd4, 8'(i));
    rd(3'd2, v); chk(v == 8'h82, "R9", "half-full at 4", v, 8'h82);
    for (int i = 4; i < 9; i++) wr(3'd4, 8'(i));
    rd(3'd5, v); chk(v == 8'd8, "R5", "LEVEL capped at 8", v, 8);
    rd(3'd2, v); chk(v == 8'h86, "R5", "overflow flag", v, 8'h86);
    chk(irq == 1, "R10", "irq on enabled error flag", irq, 1);
    set_count(300);
    wr(3'd0, 8'h01);
    rd(3'd5, v); chk(v == 8'd0, "R12", "FIFO emptied", v, 0);
    rd(3'd2, v); chk(v == 8'h80, "R12", "flags cleared and free", v, 8'h80);
    rd(3'd7, v); chk(v == 8'd0, "R12", "count cleared", v, 0);
    rd(3'd0, v); chk(v == 8'h00, "R12", "clear bit reads 0", v, 0);
    chk(irq == 0, "R12", "irq after all-clear", irq, 0);
    // With the shifter stopped mid-byte, reset the monitor phase
    mbit = 0; sbit = 0; per_ok = 1; exp_q.delete();
    // R6 receive
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h04);
    slv_q = '{8'hA5, 8'h3C, 8'h81};
    miso = slv_bit();
    for (int i = 0; i < 3; i++) exp_q.push_back(8'hFF);
    set_count(3);
    wait_free("R6");
    rd(3'd5, v); chk(v == 8'd3, "R6", "RX level", v, 3);
    rd(3'd4, v); chk(v == 8'hA5, "R6", "RX byte 0", v, 8'hA5);
    rd(3'd4, v); chk(v == 8'h3C, "R6", "RX byte 1", v, 8'h3C);
    rd(3'd4, v); chk(v == 8'h81, "R6", "RX byte 2", v, 8'h81);
    rd(3'd4, v); chk(v == 8'h00, "R6", "empty read value", v, 0);
    rd(3'd2, v); chk(v[2] == 1, "R6", "underflow flag", v[2], 1);
    // R8 receive stall when full
    wr(3'd2, 8'h0F);
    for (int i = 0; i < 10; i++) begin
      rxv[i] = 8'(8'h11 * i + 8'h07);
      slv_q.push_back(rxv[i]);
      exp_q.push_back(8'hFF);
    end
    miso = slv_bit();
    set_count(10);
    begin
      bit full = 0;
      for (int i = 0; i < 2000 && !full; i++) begin
        rd(3'd5, v);
        if (v == 8'd8) full = 1;
      end
      chk(full, "R8", "RX FIFO filled", v, 8);
    end
    r0 = rise_n;
    repeat (40) @(negedge clk);
    chk(rise_n == r0, "R8", "no SCK with full RX FIFO", rise_n - r0, 0);
    rd(3'd6, v); chk(v == 8'd2, "R8", "count held at 2", v, 2);
    for (int i = 0; i < 8; i++) begin
      rd(3'd4, v); chk(v == rxv[i], "R6", "RX stream byte", v, rxv[i]);
    end
    wait_free("R8");
    for (int i = 8; i < 10; i++) begin
      rd(3'd4, v); chk(v == rxv[i], "R6", "RX stream tail", v, rxv[i]);
    end
    // R11 automatic byte-end clear
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h0F);
    send(8'hE7);
    set_count(1);
    wait_free("R11");
    rd(3'd2, v); chk(v[0] == 1, "R11", "byte-end set", v[0], 1);
    rd(3'd4, v);
    rd(3'd2, v); chk(v[0] == 0, "R11", "byte-end cleared by DATA access", v[0], 0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all queued bytes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule